// File: doc/BRIEF.md
# Packed-Control Event Counter Bank

This block keeps four free-running 32-bit event counters behind a small register bus. All four counters are configured through one shared 32-bit control word. Each counter owns one byte lane of that word, and a 5-bit event code sits one bit above the bottom of its lane. A code of zero parks the counter at its current value. A nonzero code picks one of 32 event inputs and counts every clock edge where that input is high. Code 1 is special: it counts every clock, whatever the event inputs are doing.

Software changes one counter's code by reading the shared word, editing one lane and writing the whole word back. Bits outside the four code fields are never stored and always read as zero, so the round trip cannot disturb the other counters. Each counter also has its own data register on a 12-byte stride. A read returns the live count, and a write loads a new value, which is usually zero to clear it. The counters raise no interrupt. They wrap modulo 2^32, and software must sample them often enough to catch every wrap.

Reads are registered. The word addressed in the cycle `bus_rd` is high appears on `bus_rdata` after the next rising edge and stays there until the next read.

Top module: `pctl_event_bank`

## Requirements
- R1: After synchronous reset, every code field and every counter is zero, and reads of the control word and of all four data registers return 0.
- R2: The control word at byte address 0x234 stores only bits [8k+5:8k+1] for counter k (k = 0..3). All other bits are ignored on write and read back as 0, so writing 0xFFFFFFFF reads back 0x3E3E3E3E.
- R3: A counter whose code field is 0 keeps its value, whatever the event inputs do.
- R4: Code 0x01 adds one to its counter on every clock edge, independent of `ev_in`.
- R5: A code c with 2 <= c <= 31 adds one on each clock edge where `ev_in[c]` is high. Codes 0x0B, 0x0D and 0x0F are the write-transaction, 16-byte data-beat and read-transaction events.
- R6: Counter k's data register sits at byte address 0x240 + 12·k. A read returns its count, and a write loads `bus_wdata` into it, so writing zero clears it.
- R7: When a data-register write and an increment of the same counter fall on the same edge, the written value is stored and the increment is lost.
- R8: A counter holding 0xFFFFFFFF that increments becomes 0x00000000.
- R9: A read-modify-write of the control word that changes one lane leaves the other counters' codes, and so their counting, unchanged.
- R10: A read of any address other than the control word and the four data registers returns 0. Read data appear on `bus_rdata` after the rising edge that samples `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_in | input | 32 | Event inputs; bit c is counted by code c |

## Verification
The hardest situation to reach from the ports is a collision on a single edge: a data write landing on a counter that is incrementing, and a control rewrite that must leave running neighbours untouched. The directed part of the stimulus makes these collisions on purpose. It writes a counter while code 1 runs it, it loads 0xFFFFFFFF just ahead of a wrap, and it rewrites the control word using the value just read back. A seeded random phase then mixes control writes, data writes, reads and event patterns, so the collisions also recur at arbitrary points.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int LANE_W   = 8;   // one control lane per counter
  localparam int CODE_W   = 5;   // event code width
  localparam int CODE_LSB = 1;   // code field offset inside a lane

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_OFF    = 5'h00;
  localparam code_t CODE_CYCLES = 5'h01;
  localparam code_t CODE_WR_TXN = 5'h0B;
  localparam code_t CODE_BEAT   = 5'h0D;
  localparam code_t CODE_RD_TXN = 5'h0F;

  function automatic int field_lo(input int k);
    return k * LANE_W + CODE_LSB;
  endfunction
endpackage

// File: rtl/evb_dec.sv
module evb_dec #(
  parameter int ADDR_W      = 12,
  parameter int NUM_CNT     = 4,
  parameter int CTRL_ADDR   = 'h234,
  parameter int DATA_BASE   = 'h240,
  parameter int DATA_STRIDE = 12,
  localparam int IDX_W      = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               ctrl_hit,
  output logic [NUM_CNT-1:0] data_hit,
  output logic               any_data,
  output logic [IDX_W-1:0]   data_idx
);
  assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_hit
    assign data_hit[k] = (addr == ADDR_W'(DATA_BASE + DATA_STRIDE * k));
  end

  assign any_data = |data_hit;

  always_comb begin
    data_idx = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (data_hit[k]) data_idx = IDX_W'(k);
    end
  end

  // R6: the data windows never overlap each other or the control word
  always_comb begin
    a_r6_single_target: assert ($onehot0({ctrl_hit, data_hit}));
  end
endmodule

// File: rtl/evb_ctrl.sv
module evb_ctrl
  import evb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int WORD_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [WORD_W-1:0]         wdata,
  output logic [NUM_CNT*CODE_W-1:0] codes,
  output logic [WORD_W-1:0]         rd_word
);
  code_t field_q [NUM_CNT];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_lane
    localparam int LO = field_lo(k);

    always_ff @(posedge clk) begin
      if (rst)        field_q[k] <= CODE_OFF;
      else if (wr_en) field_q[k] <= wdata[LO +: CODE_W];
    end

    assign codes[k*CODE_W +: CODE_W] = field_q[k];

    // R2: a write captures exactly the lane's code bits
    a_r2_field_load: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> codes[k*CODE_W +: CODE_W] == $past(wdata[LO +: CODE_W]));
    // R9: without a write, every lane holds its code
    a_r9_field_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(codes[k*CODE_W +: CODE_W]));
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      rd_word[field_lo(k) +: CODE_W] = field_q[k];
    end
  end
endmodule

// File: rtl/evb_counter.sv
module evb_counter
  import evb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_EV = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  code_t             code,
  input  logic [NUM_EV-1:0] ev,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  cnt
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    if (code == CODE_CYCLES)                          hit = 1'b1;
    else if (code != CODE_OFF && int'(code) < NUM_EV) hit = ev[code];
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (hit)  cnt <= cnt + CNT_W'(1);
  end

  // R3: a parked counter keeps its value
  a_r3_off_holds: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_OFF && !load) |=> $stable(cnt));
  // R4: the cycle code advances the counter by one every edge
  a_r4_cycle_step: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_CYCLES && !load) |=> cnt == $past(cnt) + CNT_W'(1));
  // R7: a load beats a same-edge increment
  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
  // R8: the all-ones value wraps to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && code == CODE_CYCLES && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/pctl_event_bank.sv
module pctl_event_bank
  import evb_pkg::*;
#(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  parameter int NUM_EV      = 32,
  parameter int ADDR_W      = 12,
  parameter int CTRL_ADDR   = 'h234,
  parameter int DATA_BASE   = 'h240,
  parameter int DATA_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_EV-1:0] ev_in
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  function automatic logic [CNT_W-1:0] field_mask();
    logic [CNT_W-1:0] m = '0;
    for (int k = 0; k < NUM_CNT; k++) m[field_lo(k) +: CODE_W] = '1;
    return m;
  endfunction
  localparam logic [CNT_W-1:0] FIELD_MASK = field_mask();

  logic                      ctrl_hit, any_data;
  logic [NUM_CNT-1:0]        data_hit;
  logic [IDX_W-1:0]          data_idx;
  logic [NUM_CNT*CODE_W-1:0] codes;
  logic [CNT_W-1:0]          ctrl_word;
  logic [CNT_W-1:0]          cnt_q [NUM_CNT];

  evb_dec #(
    .ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .CTRL_ADDR(CTRL_ADDR),
    .DATA_BASE(DATA_BASE), .DATA_STRIDE(DATA_STRIDE)
  ) u_dec (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .data_hit(data_hit),
    .any_data(any_data), .data_idx(data_idx)
  );

  evb_ctrl #(.NUM_CNT(NUM_CNT), .WORD_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr && ctrl_hit),
    .wdata(bus_wdata), .codes(codes), .rd_word(ctrl_word)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    evb_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_cnt (
      .clk(clk), .rst(rst),
      .code(codes[k*CODE_W +: CODE_W]), .ev(ev_in),
      .load(bus_wr && data_hit[k]), .load_val(bus_wdata),
      .cnt(cnt_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (ctrl_hit)      bus_rdata <= ctrl_word;
      else if (any_data) bus_rdata <= cnt_q[data_idx];
      else               bus_rdata <= '0;
    end
  end

  // R2: reserved control bits always read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ctrl_hit) |=> (bus_rdata & ~FIELD_MASK) == '0);
  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !ctrl_hit && !any_data) |=> bus_rdata == '0);
  // R10: read data change only after a read
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/pctl_event_bank_tb.sv
`timescale 1ns/1ps
module pctl_event_bank_tb;
  localparam logic [11:0] CTRL = 12'h234;
  localparam int CYCLE_LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, ev_in = '0;
  logic [31:0] bus_rdata;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [4:0]  m_code [4];
  logic [31:0] m_cnt  [4];

  always #4 clk = ~clk;

  pctl_event_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_in(ev_in)
  );

  function automatic logic [11:0] daddr(input int k);
    return 12'(12'h240 + 12 * k);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] w = '0;
    if (a == CTRL) begin
      for (int k = 0; k < 4; k++) w[8*k+1 +: 5] = m_code[k];
      return w;
    end
    for (int k = 0; k < 4; k++) if (a == daddr(k)) return m_cnt[k];
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check read after it
  task automatic step(input string req, input logic wr, input logic rd,
                      input logic [11:0] a, input logic [31:0] wd, input logic [31:0] ev);
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; ev_in = ev;
    exp_rd = model_read(a);
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      if (wr && a == daddr(k))                              m_cnt[k] = wd;
      else if (m_code[k] == 5'h01)                          m_cnt[k] = m_cnt[k] + 1;
      else if (m_code[k] != 5'h00 && ev[m_code[k]])         m_cnt[k] = m_cnt[k] + 1;
    end
    if (wr && a == CTRL)
      for (int k = 0; k < 4; k++) m_code[k] = wd[8*k+1 +: 5];
    #1;
    if (rd) check(req, bus_rdata, exp_rd);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n, input logic [31:0] ev);
    for (int i = 0; i < n; i++) step("", 1'b0, 1'b0, '0, '0, ev);
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    step(req, 1'b0, 1'b1, a, '0, $urandom);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step("", 1'b1, 1'b0, a, d, '0);
  endtask

  initial begin
    logic [31:0] word;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin m_code[k] = '0; m_cnt[k] = '0; end
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    rd("R1", CTRL);
    for (int k = 0; k < 4; k++) rd("R1", daddr(k));
    check("R1", bus_rdata, 32'h0);

    // R2: only code fields are stored
    wr(CTRL, 32'hFFFF_FFFF);
    rd("R2", CTRL);
    check("R2", bus_rdata, 32'h3E3E_3E3E);
    wr(CTRL, 32'h0);
    for (int k = 0; k < 4; k++) wr(daddr(k), 32'h0);

    // R4: cycle code counts without events
    wr(CTRL, 32'h0000_0002);
    idle(10, 32'h0);
    rd("R4", daddr(0));
    for (int k = 1; k < 4; k++) rd("R3", daddr(k));

    // R5: event codes count their inputs
    wr(CTRL, {2'b0, 5'h0F, 1'b0, 2'b0, 5'h0D, 1'b0, 2'b0, 5'h0B, 1'b0, 8'h00});
    for (int i = 0; i < 40; i++) step("", 1'b0, 1'b0, '0, '0, $urandom);
    for (int k = 0; k < 4; k++) rd("R5", daddr(k));

    // R3: stopped counters ignore events
    wr(CTRL, 32'h0);
    for (int k = 0; k < 4; k++) rd("R3", daddr(k));
    idle(8, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) rd("R3", daddr(k));

    // R6: data write loads and clears
    wr(daddr(2), 32'h0);
    rd("R6", daddr(2));
    check("R6", bus_rdata, 32'h0);
    wr(daddr(3), 32'h1234_5678);
    rd("R6", daddr(3));
    check("R6", bus_rdata, 32'h1234_5678);

    // R7: write beats increment
    wr(CTRL, 32'h0000_0002);
    idle(3, '0);
    wr(daddr(0), 32'h0000_0055);
    rd("R7", daddr(0));
    check("R7", bus_rdata, 32'h0000_0055);

    // R8: wrap
    wr(daddr(0), 32'hFFFF_FFFF);
    idle(1, '0);
    rd("R8", daddr(0));
    check("R8", bus_rdata, 32'h0);

    // R9: read-modify-write of one lane
    wr(CTRL, 32'h1E00_1602);
    rd("R9", CTRL);
    word = bus_rdata;
    word[8*2+1 +: 5] = 5'h0D;
    step("", 1'b1, 1'b0, CTRL, word, '0);
    rd("R9", CTRL);
    check("R9", bus_rdata, 32'h1E1A_1602);
    for (int i = 0; i < 20; i++) step("", 1'b0, 1'b0, '0, '0, $urandom);
    for (int k = 0; k < 4; k++) rd("R9", daddr(k));

    // R10: unmapped addresses
    rd("R10", 12'h238);
    rd("R10", 12'h000);
    rd("R10", 12'h244);
    check("R10", bus_rdata, 32'h0);

    // random mix, checked against the model (R5 and neighbours)
    for (int i = 0; i < 600; i++) begin
      int sel = int'($urandom_range(0, 9));
      int k   = int'($urandom_range(0, 3));
      case (sel)
        0, 1, 2: rd("R5", ($urandom_range(0, 4) == 0) ? CTRL : daddr(k));
        3:       step("", 1'b1, 1'b0, CTRL, $urandom, $urandom);
        4:       step("", 1'b1, 1'b0, daddr(k),
                      ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFE : $urandom, $urandom);
        5:       rd("R10", 12'($urandom));
        default: step("", 1'b0, 1'b0, '0, '0, $urandom);
      endcase
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (CYCLE_LIMIT) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule